// File: doc/BRIEF.md
# Monitor Control Register with Timed Pulse Outputs

This block is the master control register of a hardware-monitor controller. Software writes it over a simple register bus that has an address, write data, a write strobe and registered read data. The register drives several things:
- a run-enable for the monitoring sequencer;
- enable, polarity and clear controls for the interrupt line;
- a general-purpose output;
- two timed pulses: a reset-out pulse and a low-going chassis-intrusion clear pulse.

A second register, at address 05h, holds two gating bits. The reset-out pulse needs them. The other fields at that address belong to neighbouring logic.

Writing the initialise bit returns this block to its power-on state. It also raises a one-cycle strobe, `init_strobe`, which the neighbouring registers use to re-initialise themselves: the interrupt status and mask registers, the fan divisor, the OS configuration, the conversion rate, the channel disable register and the two top storage locations. A hard reset also raises that strobe. There are two ways to reset the block:
- the synchronous `rst`;
- an asynchronous active-low external reset pin. It is synchronised internally, so a low pulse of 50 ns or more is caught.

Both pulses last `PULSE_CYC` clock cycles. The default corresponds to 10 ms at 200 MHz.

Top module: `mon_ctl_top`

## Requirements
- R1: After reset, address 00h reads 0x08 (interrupt clear set, everything else clear) and address 05h reads 0x00. `run_en`, `irq_out`, `rst_out` and `gpo` are 0, and `chassis_clr_n` is 1.
- R2: The control register bit layout is: bit0 start, bit1 interrupt enable, bit2 polarity, bit3 interrupt clear, bit4 reset-out request, bit5 chassis clear, bit6 GPO, bit7 initialise. Bits 0, 1, 2, 3 and 6 read back as written, and bit 7 always reads 0. Address 05h keeps only bit6 (OS pin enable) and bit7 (reset-out enable), and its other bits read 0. Any other address reads 0.
- R3: A write to 00h with bit7=1 returns both registers to their R1 values and cancels both pulses, whatever the other written bits are. `init_strobe` is 1 for exactly the one cycle after that write.
- R4: `run_en` is 1 only when start=1 and interrupt clear=0. It follows the register one clock after the write edge.
- R5: `irq_out` equals (interrupt enable AND `irq_pending` AND NOT interrupt clear) XOR polarity. It is registered one clock after its inputs.
- R6: Writing bit4=1 while 05h has bit6=0 and bit7=1 drives `rst_out` high for exactly `PULSE_CYC` cycles. Bit 4 reads 1 while the pulse runs and 0 afterwards.
- R7: With any other value of 05h bits 7:6, a bit4 write is ignored: no pulse is produced and bit4 reads 0.
- R8: While interrupt clear is 1, `rst_out` stays 0 even while a reset-out pulse is being timed.
- R9: Writing bit5=1 drives `chassis_clr_n` low for exactly `PULSE_CYC` cycles. Bit 5 reads 1 while the pulse runs and 0 afterwards.
- R10: Writing bit4 or bit5 (as 1 or 0) during a running pulse neither restarts it nor shortens it.
- R11: Holding `ext_rst_n` low for 10 or more cycles returns the block to the R1 state, and `init_strobe` stays 1 while the reset is held.
- R12: `gpo` follows bit 6 one clock after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_rst_n | input | 1 | Asynchronous active-low external reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 8 | Read data for the address of the previous cycle |
| irq_pending | input | 1 | An interrupt is pending in the status logic |
| run_en | output | 1 | Run-enable for the monitoring loop |
| irq_out | output | 1 | Interrupt line, polarity applied |
| rst_out | output | 1 | Reset-out pulse, active high |
| chassis_clr_n | output | 1 | Chassis-intrusion clear, active low |
| gpo | output | 1 | General-purpose output |
| init_strobe | output | 1 | Re-initialise request to neighbouring registers |

## Verification
A register write takes effect on its own edge. The registered outputs `run_en`, `irq_out`, `gpo` and `chassis_clr_n` therefore change one edge after the write. `bus_rdata` shows the state one edge after the address is presented. `init_strobe` is already high just after the initialising write edge. The bench drives and samples on falling edges and waits that exact number of edges before each comparison. It measures pulse widths with a counter that samples shortly after each rising edge, and compares the count against `PULSE_CYC`.

// File: rtl/mon_ctl_pkg.sv
package mon_ctl_pkg;
  localparam int DATA_W = 8;

  // control register bit positions (software-visible layout)
  localparam int B_START = 0;
  localparam int B_IEN   = 1;
  localparam int B_POL   = 2;
  localparam int B_ICLR  = 3;
  localparam int B_RSREQ = 4;
  localparam int B_CHCLR = 5;
  localparam int B_GPO   = 6;
  localparam int B_INIT  = 7;

  // gating register bit positions
  localparam int B_OSEN  = 6;
  localparam int B_RSEN  = 7;

  localparam logic [DATA_W-1:0] CTL_RESET = 8'h08;

  // pulse channel indices
  localparam int CH_RS  = 0;
  localparam int CH_CHS = 1;
  localparam int N_PULSE = 2;
endpackage

// File: rtl/mon_rst_sync.sv
module mon_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic ext_rst_n,
  output logic ext_rst
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge ext_rst_n) begin
    if (!ext_rst_n) sync_q <= '0;
    else            sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign ext_rst = ~sync_q[STAGES-1];
endmodule

// File: rtl/mon_pulse_timer.sv
module mon_pulse_timer #(
  parameter int PULSE_CYC = 2000000
) (
  input  logic clk,
  input  logic clr,
  input  logic start,
  output logic active
);
  localparam int CNT_W = $clog2(PULSE_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (clr)                    cnt_q <= '0;
    else if (start && !active)  cnt_q <= CNT_W'(PULSE_CYC);
    else if (active)            cnt_q <= cnt_q - 1'b1;
  end

  assign active = (cnt_q != '0);
endmodule

// File: rtl/mon_ctl_regs.sv
module mon_ctl_regs
  import mon_ctl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTL_ADDR  = ADDR_W'(8'h00),
  parameter logic [ADDR_W-1:0] GATE_ADDR = ADDR_W'(8'h05)
) (
  input  logic              clk,
  input  logic              rst_any,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic [N_PULSE-1:0] pulse_act,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              ctl_start,
  output logic              ctl_ien,
  output logic              ctl_pol,
  output logic              ctl_iclr,
  output logic              ctl_gpo,
  output logic              os_en,
  output logic              rs_en,
  output logic              soft_init,
  output logic [N_PULSE-1:0] pulse_start,
  output logic              init_q
);
  logic wr_ctl, wr_gate;

  assign wr_ctl    = bus_we && (bus_addr == CTL_ADDR);
  assign wr_gate   = bus_we && (bus_addr == GATE_ADDR);
  assign soft_init = wr_ctl && bus_wdata[B_INIT];

  assign pulse_start[CH_RS]  = wr_ctl && !bus_wdata[B_INIT] && bus_wdata[B_RSREQ]
                               && !os_en && rs_en;
  assign pulse_start[CH_CHS] = wr_ctl && !bus_wdata[B_INIT] && bus_wdata[B_CHCLR];

  always_ff @(posedge clk) begin
    if (rst_any) begin
      ctl_start <= CTL_RESET[B_START];
      ctl_ien   <= CTL_RESET[B_IEN];
      ctl_pol   <= CTL_RESET[B_POL];
      ctl_iclr  <= CTL_RESET[B_ICLR];
      ctl_gpo   <= CTL_RESET[B_GPO];
      os_en     <= 1'b0;
      rs_en     <= 1'b0;
      init_q    <= 1'b1;
    end else begin
      init_q <= soft_init;
      if (soft_init) begin
        ctl_start <= CTL_RESET[B_START];
        ctl_ien   <= CTL_RESET[B_IEN];
        ctl_pol   <= CTL_RESET[B_POL];
        ctl_iclr  <= CTL_RESET[B_ICLR];
        ctl_gpo   <= CTL_RESET[B_GPO];
        os_en     <= 1'b0;
        rs_en     <= 1'b0;
      end else begin
        if (wr_ctl) begin
          ctl_start <= bus_wdata[B_START];
          ctl_ien   <= bus_wdata[B_IEN];
          ctl_pol   <= bus_wdata[B_POL];
          ctl_iclr  <= bus_wdata[B_ICLR];
          ctl_gpo   <= bus_wdata[B_GPO];
        end
        if (wr_gate) begin
          os_en <= bus_wdata[B_OSEN];
          rs_en <= bus_wdata[B_RSEN];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_any) begin
      bus_rdata <= '0;
    end else if (bus_addr == CTL_ADDR) begin
      bus_rdata          <= '0;
      bus_rdata[B_START] <= ctl_start;
      bus_rdata[B_IEN]   <= ctl_ien;
      bus_rdata[B_POL]   <= ctl_pol;
      bus_rdata[B_ICLR]  <= ctl_iclr;
      bus_rdata[B_RSREQ] <= pulse_act[CH_RS];
      bus_rdata[B_CHCLR] <= pulse_act[CH_CHS];
      bus_rdata[B_GPO]   <= ctl_gpo;
    end else if (bus_addr == GATE_ADDR) begin
      bus_rdata         <= '0;
      bus_rdata[B_OSEN] <= os_en;
      bus_rdata[B_RSEN] <= rs_en;
    end else begin
      bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/mon_ctl_outs.sv
module mon_ctl_outs
  import mon_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_any,
  input  logic              ctl_start,
  input  logic              ctl_ien,
  input  logic              ctl_pol,
  input  logic              ctl_iclr,
  input  logic              ctl_gpo,
  input  logic              irq_pending,
  input  logic [N_PULSE-1:0] pulse_act,
  output logic              run_en,
  output logic              irq_out,
  output logic              rst_out,
  output logic              chassis_clr_n,
  output logic              gpo
);
  always_ff @(posedge clk) begin
    if (rst_any) begin
      run_en        <= 1'b0;
      irq_out       <= 1'b0;
      rst_out       <= 1'b0;
      chassis_clr_n <= 1'b1;
      gpo           <= 1'b0;
    end else begin
      run_en        <= ctl_start && !ctl_iclr;
      irq_out       <= (ctl_ien && irq_pending && !ctl_iclr) ^ ctl_pol;
      rst_out       <= pulse_act[CH_RS] && !ctl_iclr;
      chassis_clr_n <= !pulse_act[CH_CHS];
      gpo           <= ctl_gpo;
    end
  end
endmodule

// File: rtl/mon_ctl_top.sv
module mon_ctl_top
  import mon_ctl_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int PULSE_CYC = 2000000,
  parameter int SYNC_STG  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_we,
  output logic [7:0]        bus_rdata,
  input  logic              irq_pending,
  output logic              run_en,
  output logic              irq_out,
  output logic              rst_out,
  output logic              chassis_clr_n,
  output logic              gpo,
  output logic              init_strobe
);
  logic ext_rst, rst_any, soft_init;
  logic ctl_start, ctl_ien, ctl_pol, ctl_iclr, ctl_gpo, os_en, rs_en;
  logic [N_PULSE-1:0] pulse_start, pulse_act;
  logic rs_active, ch_active;

  mon_rst_sync #(.STAGES(SYNC_STG)) i_sync (
    .clk(clk), .ext_rst_n(ext_rst_n), .ext_rst(ext_rst)
  );

  assign rst_any = rst || ext_rst;

  mon_ctl_regs #(.ADDR_W(ADDR_W)) i_regs (
    .clk(clk), .rst_any(rst_any),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .pulse_act(pulse_act), .bus_rdata(bus_rdata),
    .ctl_start(ctl_start), .ctl_ien(ctl_ien), .ctl_pol(ctl_pol),
    .ctl_iclr(ctl_iclr), .ctl_gpo(ctl_gpo),
    .os_en(os_en), .rs_en(rs_en), .soft_init(soft_init),
    .pulse_start(pulse_start), .init_q(init_strobe)
  );

  for (genvar g = 0; g < N_PULSE; g++) begin : g_pulse
    mon_pulse_timer #(.PULSE_CYC(PULSE_CYC)) i_timer (
      .clk(clk), .clr(rst_any || soft_init),
      .start(pulse_start[g]), .active(pulse_act[g])
    );
  end

  assign rs_active = pulse_act[CH_RS];
  assign ch_active = pulse_act[CH_CHS];

  mon_ctl_outs i_outs (
    .clk(clk), .rst_any(rst_any),
    .ctl_start(ctl_start), .ctl_ien(ctl_ien), .ctl_pol(ctl_pol),
    .ctl_iclr(ctl_iclr), .ctl_gpo(ctl_gpo), .irq_pending(irq_pending),
    .pulse_act(pulse_act),
    .run_en(run_en), .irq_out(irq_out), .rst_out(rst_out),
    .chassis_clr_n(chassis_clr_n), .gpo(gpo)
  );
endmodule

// File: rtl/mon_ctl_chk.sv
module mon_ctl_chk #(
  parameter int PULSE_CYC = 2000000
) (
  input logic clk,
  input logic rst_any,
  input logic soft_init,
  input logic ctl_start,
  input logic ctl_iclr,
  input logic ctl_pol,
  input logic os_en,
  input logic rs_en,
  input logic rs_active,
  input logic ch_active,
  input logic run_en,
  input logic irq_out,
  input logic rst_out
);
  logic [31:0] ch_run;

  always_ff @(posedge clk) begin
    if (rst_any || !ch_active) ch_run <= '0;
    else                       ch_run <= ch_run + 1'b1;
  end

  a_r4_run_needs_start: assert property (@(posedge clk) disable iff (rst_any)
    run_en |-> $past(ctl_start && !ctl_iclr));

  a_r5_irq_idle_level: assert property (@(posedge clk) disable iff (rst_any)
    ctl_iclr |=> (irq_out == $past(ctl_pol)));

  a_r7_rs_gated: assert property (@(posedge clk) disable iff (rst_any)
    $rose(rs_active) |-> $past(!os_en && rs_en));

  a_r8_rst_out_masked: assert property (@(posedge clk) disable iff (rst_any)
    ctl_iclr |=> !rst_out);

  a_r3_init_restores: assert property (@(posedge clk) disable iff (rst_any)
    soft_init |=> (ctl_iclr && !ctl_start && !rs_active && !ch_active));

  a_r9_pulse_len: assert property (@(posedge clk) disable iff (rst_any)
    ch_run <= PULSE_CYC);
endmodule

bind mon_ctl_top mon_ctl_chk #(.PULSE_CYC(PULSE_CYC)) i_chk (
  .clk(clk), .rst_any(rst_any), .soft_init(soft_init),
  .ctl_start(ctl_start), .ctl_iclr(ctl_iclr), .ctl_pol(ctl_pol),
  .os_en(os_en), .rs_en(rs_en), .rs_active(rs_active), .ch_active(ch_active),
  .run_en(run_en), .irq_out(irq_out), .rst_out(rst_out)
);

// File: tb/test_mon_ctl_top.sv
`timescale 1ns/1ps
module test_mon_ctl_top;
  localparam int P = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ext_rst_n = 1'b1;
  logic [7:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_rdata;
  logic       irq_pending = 1'b0;
  logic       run_en, irq_out, rst_out, chassis_clr_n, gpo, init_strobe;

  int n_chk = 0;
  int n_bad = 0;
  int ch_low = 0;
  int rs_high = 0;

  always #2.5 clk = ~clk;

  mon_ctl_top #(.ADDR_W(8), .PULSE_CYC(P)) i_mon_ctl_top (
    .clk(clk), .rst(rst), .ext_rst_n(ext_rst_n),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .bus_rdata(bus_rdata), .irq_pending(irq_pending),
    .run_en(run_en), .irq_out(irq_out), .rst_out(rst_out),
    .chassis_clr_n(chassis_clr_n), .gpo(gpo), .init_strobe(init_strobe)
  );

  // pulse-width counters sampled just after each rising edge
  always begin
    @(posedge clk);
    #1;
    if (!chassis_clr_n) ch_low++;
    if (rst_out) rs_high++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(8'h00, d); check("R1 ctl reset", d, 8'h08);
    rd(8'h05, d); check("R1 gate reset", d, 8'h00);
    check("R1 outputs", {run_en, irq_out, rst_out, chassis_clr_n, gpo}, 5'b00010);
  endtask

  task automatic t_rw;
    logic [7:0] d;
    wr(8'h00, 8'h47); rd(8'h00, d); check("R2 ctl readback", d, 8'h47);
    wr(8'h05, 8'hFF); rd(8'h05, d); check("R2 gate readback", d, 8'hC0);
    rd(8'h10, d); check("R2 unmapped read", d, 8'h00);
    wr(8'h00, 8'h08); wr(8'h05, 8'h00);
  endtask

  task automatic t_run;
    wr(8'h00, 8'h01);
    check("R4 run latency", run_en, 1'b0);
    cyc(1); check("R4 run on", run_en, 1'b1);
    wr(8'h00, 8'h09); cyc(1); check("R4 run blocked by clear", run_en, 1'b0);
    wr(8'h00, 8'h08); cyc(1); check("R4 run off", run_en, 1'b0);
  endtask

  task automatic t_irq;
    wr(8'h00, 8'h02);
    irq_pending = 1'b1; cyc(1); check("R5 irq active", irq_out, 1'b1);
    irq_pending = 1'b0; cyc(1); check("R5 irq idle", irq_out, 1'b0);
    wr(8'h00, 8'h06); cyc(1); check("R5 inverted idle", irq_out, 1'b1);
    irq_pending = 1'b1; cyc(1); check("R5 inverted active", irq_out, 1'b0);
    wr(8'h00, 8'h0E); cyc(1); check("R5 clear forces idle", irq_out, 1'b1);
    wr(8'h00, 8'h04); cyc(1); check("R5 disabled", irq_out, 1'b1);
    irq_pending = 1'b0;
    wr(8'h00, 8'h08); cyc(1);
  endtask

  task automatic t_rst_pulse;
    logic [7:0] d;
    wr(8'h05, 8'h80);
    @(negedge clk); rs_high = 0;
    wr(8'h00, 8'h10);
    rd(8'h00, d); check("R6 bit4 while running", d, 8'h10);
    cyc(P + 5);
    check("R6 rst_out width", rs_high, P);
    rd(8'h00, d); check("R6 bit4 after pulse", d, 8'h00);
    wr(8'h00, 8'h08);
  endtask

  task automatic t_gating;
    logic [7:0] d;
    wr(8'h05, 8'hC0);
    @(negedge clk); rs_high = 0;
    wr(8'h00, 8'h10);
    rd(8'h00, d); check("R7 os enable blocks", d, 8'h00);
    wr(8'h05, 8'h00);
    wr(8'h00, 8'h10);
    cyc(P + 5);
    check("R7 no pulse when gated", rs_high, 0);
    rd(8'h00, d); check("R7 bit4 stays 0", d, 8'h00);
    wr(8'h00, 8'h08);
  endtask

  task automatic t_iclr_mask;
    logic [7:0] d;
    wr(8'h05, 8'h80);
    @(negedge clk); rs_high = 0;
    wr(8'h00, 8'h18);
    rd(8'h00, d); check("R8 pulse timed under clear", d, 8'h18);
    cyc(P + 5);
    check("R8 rst_out masked", rs_high, 0);
    wr(8'h05, 8'h00);
  endtask

  task automatic t_chassis;
    logic [7:0] d;
    @(negedge clk); ch_low = 0;
    wr(8'h00, 8'h20);
    rd(8'h00, d); check("R9 bit5 while running", d, 8'h20);
    cyc(P + 5);
    check("R9 chassis low width", ch_low, P);
    rd(8'h00, d); check("R9 bit5 after pulse", d, 8'h00);
  endtask

  task automatic t_no_restart;
    @(negedge clk); ch_low = 0;
    wr(8'h00, 8'h20);
    cyc(5);
    wr(8'h00, 8'h20);
    cyc(3);
    wr(8'h00, 8'h00);
    cyc(P + 5);
    check("R10 no restart or cut", ch_low, P);
    wr(8'h00, 8'h08);
  endtask

  task automatic t_soft_init;
    logic [7:0] d;
    wr(8'h05, 8'h80);
    wr(8'h00, 8'h67);
    cyc(2);
    check("R3 chassis running before init", chassis_clr_n, 1'b0);
    wr(8'h00, 8'hFF);
    check("R3 init strobe", init_strobe, 1'b1);
    cyc(1);
    check("R3 init strobe one cycle", init_strobe, 1'b0);
    check("R3 outputs restored", {run_en, rst_out, chassis_clr_n, gpo}, 4'b0010);
    rd(8'h00, d); check("R3 ctl restored", d, 8'h08);
    rd(8'h05, d); check("R3 gate restored", d, 8'h00);
  endtask

  task automatic t_gpo;
    wr(8'h00, 8'h48); cyc(1); check("R12 gpo set", gpo, 1'b1);
    wr(8'h00, 8'h08); cyc(1); check("R12 gpo clear", gpo, 1'b0);
  endtask

  task automatic t_ext_reset;
    logic [7:0] d;
    wr(8'h05, 8'h80);
    wr(8'h00, 8'h41);
    cyc(2);
    check("R11 running before", run_en, 1'b1);
    @(negedge clk); ext_rst_n = 1'b0;
    cyc(2);
    check("R11 init held", init_strobe, 1'b1);
    check("R11 run dropped", run_en, 1'b0);
    cyc(10);
    ext_rst_n = 1'b1;
    cyc(4);
    check("R11 strobe released", init_strobe, 1'b0);
    check("R11 outputs", {run_en, irq_out, rst_out, chassis_clr_n, gpo}, 5'b00010);
    rd(8'h00, d); check("R11 ctl", d, 8'h08);
    rd(8'h05, d); check("R11 gate", d, 8'h00);
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    cyc(5);
    rst = 1'b0;
    cyc(2);
    t_reset();
    t_rw();
    t_run();
    t_irq();
    t_rst_pulse();
    t_gating();
    t_iclr_mask();
    t_chassis();
    t_no_restart();
    t_soft_init();
    t_gpo();
    t_ext_reset();
    summary();
    $finish;
  end
endmodule